// File: doc/BRIEF.md
# Input Port Change Detector and Interrupt Unit

This block samples seven general-purpose input lines through a clocked synchroniser. It watches the lowest four of them for level changes. Each watched line has a sticky change flag. Software sees the four live levels and the four flags together in a single change word. Reading that word clears the flags, but a change detected on the same clock edge as the clearing read is kept.

The change flags are gated one by one by an auxiliary enable register and merged into a single port-change bit. That bit joins seven level-sensitive interrupt sources from the serial channels and the counter to form an 8-bit status word. A mask register of the same layout selects which status bits drive the single active-high interrupt output.

The register port uses shared offsets. At each of the change/enable offset and the status/mask offset, a read returns one register and a write loads the other. A third offset returns the raw synchronised input levels.

Top module: `ipc_irq_unit`

## Requirements
- R1: After synchronous reset, the change flags, the enable register and the mask register are all zero, and `irq_o` is low.
- R2: A read at address 0 returns the synchronised levels of inputs 0..3 in bits 3:0 and their change flags in bits 7:4. A level appears two clock edges after the input changes. Its flag sets one edge later on either a rising or a falling transition.
- R3: A read at address 0 clears all four change flags. A transition detected on the same edge as that read leaves its flag set.
- R4: Write-only enable bits 3:0, written at address 0, each allow the matching change flag into status bit 7. With an enable bit clear, its flag does not reach bit 7 but stays visible in the change word.
- R5: A read at address 1 returns the status word. Its bits 6:0 follow `src_lvl[6:0]` in this order: tx ready A, rx ready A, break change A, counter ready, tx ready B, rx ready B, break change B. Bit 7 is the port-change bit.
- R6: The mask register is written at address 1 with the same bit layout as the status word. `irq_o` is high one cycle after any status bit and its mask bit are both set, and low one cycle after no such pair exists.
- R7: A read at address 2 returns the synchronised levels of `gp_in[6:0]` in bits 6:0, with bit 7 always 1.
- R8: A write at address 0 leaves the change word unchanged. A write at address 1 leaves the status word unchanged.
- R9: Reading the status word, or reading address 2, leaves the change flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset: 0 change/enable, 1 status/mask, 2 raw inputs |
| reg_rd | input | 1 | Read strobe; a read at offset 0 clears the flags on this edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the offset presented, combinational |
| gp_in | input | 7 | Asynchronous general-purpose input lines |
| src_lvl | input | 7 | Channel and counter interrupt source levels, status bits 6:0 |
| irq_o | output | 1 | Registered active-high interrupt request |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high together. They also assume `gp_in` is low while reset is held, so the first synchronised sample after reset is not read as a transition. The stimulus changes every input on the falling clock edge and drives at most one strobe per cycle. It holds all input lines low through reset. The edge-time checks for levels and flags are timed in whole cycles from the falling edge on which an input changes.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int DATA_W    = 8;
    localparam int NUM_SRC   = DATA_W - 1;
    localparam int NUM_RAW   = DATA_W - 1;
    localparam int NUM_WATCH = DATA_W / 2;
    localparam int ADDR_W    = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CHG_EN   = 2'd0,
        SEL_STAT_MSK = 2'd1,
        SEL_RAW      = 2'd2,
        SEL_NONE     = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic port_chg;
        logic brk_b;
        logic rx_b;
        logic tx_b;
        logic ctr_rdy;
        logic brk_a;
        logic rx_a;
        logic tx_a;
    } irq_status_t;

    typedef struct packed {
        logic [NUM_WATCH-1:0] flags;
        logic [NUM_WATCH-1:0] levels;
    } chg_word_t;

    function automatic chg_word_t pack_chg(input logic [NUM_WATCH-1:0] lv,
                                           input logic [NUM_WATCH-1:0] fl);
        chg_word_t w;
        w.levels = lv;
        w.flags  = fl;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_raw(input logic [NUM_RAW-1:0] lv);
        return {1'b1, lv};
    endfunction

    function automatic logic any_pending(input irq_status_t st,
                                         input logic [DATA_W-1:0] msk);
        return |(DATA_W'(st) & msk);
    endfunction

endpackage

// File: rtl/ipc_sync.sv
module ipc_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[LAST];
endmodule

// File: rtl/ipc_delta_tracker.sv
module ipc_delta_tracker #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic         clr,
    output logic [W-1:0] flags,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic flag_q;
        assign hit[i] = lvl[i] ^ prev_q[i];

        // Set wins over clear so an edge seen during a clearing read survives.
        always_ff @(posedge clk) begin
            if (rst)         flag_q <= 1'b0;
            else if (hit[i]) flag_q <= 1'b1;
            else if (clr)    flag_q <= 1'b0;
        end
        assign flags[i] = flag_q;
    end
endmodule

// File: rtl/ipc_irq_merge.sv
module ipc_irq_merge
    import ipc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mask_we,
    input  logic                 en_we,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_SRC-1:0]   src,
    input  logic [NUM_WATCH-1:0] flags,
    output irq_status_t          status,
    output logic [DATA_W-1:0]    mask_q,
    output logic [NUM_WATCH-1:0] en_q,
    output logic                 irq_q
);
    logic [NUM_WATCH-1:0] gated;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            en_q   <= '0;
        end else begin
            if (mask_we) mask_q <= wdata;
            if (en_we)   en_q   <= wdata[NUM_WATCH-1:0];
        end
    end

    for (genvar i = 0; i < NUM_WATCH; i++) begin : g_gate
        assign gated[i] = flags[i] & en_q[i];
    end

    assign status = irq_status_t'({|gated, src});

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= any_pending(status, mask_q);
    end
endmodule

// File: rtl/ipc_irq_unit.sv
module ipc_irq_unit
    import ipc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_RAW-1:0] gp_in,
    input  logic [NUM_SRC-1:0] src_lvl,
    output logic              irq_o
);
    reg_sel_e             sel;
    logic [NUM_RAW-1:0]   lvl_sync;
    logic [NUM_WATCH-1:0] flags;
    logic [NUM_WATCH-1:0] edge_hit;
    logic [NUM_WATCH-1:0] en_q;
    logic [DATA_W-1:0]    mask_q;
    irq_status_t          status;
    logic                 rd_chg;
    logic                 wr_en;
    logic                 wr_mask;

    assign sel     = reg_sel_e'(reg_addr);
    assign rd_chg  = reg_rd && (sel == SEL_CHG_EN);
    assign wr_en   = reg_wr && (sel == SEL_CHG_EN);
    assign wr_mask = reg_wr && (sel == SEL_STAT_MSK);

    ipc_sync #(.W(NUM_RAW), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (gp_in),
        .dout (lvl_sync)
    );

    ipc_delta_tracker #(.W(NUM_WATCH)) u_delta (
        .clk   (clk),
        .rst   (rst),
        .lvl   (lvl_sync[NUM_WATCH-1:0]),
        .clr   (rd_chg),
        .flags (flags),
        .hit   (edge_hit)
    );

    ipc_irq_merge u_merge (
        .clk     (clk),
        .rst     (rst),
        .mask_we (wr_mask),
        .en_we   (wr_en),
        .wdata   (reg_wdata),
        .src     (src_lvl),
        .flags   (flags),
        .status  (status),
        .mask_q  (mask_q),
        .en_q    (en_q),
        .irq_q   (irq_o)
    );

    always_comb begin
        case (sel)
            SEL_CHG_EN:   reg_rdata = pack_chg(lvl_sync[NUM_WATCH-1:0], flags);
            SEL_STAT_MSK: reg_rdata = DATA_W'(status);
            SEL_RAW:      reg_rdata = pack_raw(lvl_sync);
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ipc_irq_checker.sv
module ipc_irq_checker
    import ipc_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic                 reg_rd,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic                 rd_chg,
    input logic [NUM_WATCH-1:0] flags,
    input logic [NUM_WATCH-1:0] edge_hit,
    input logic [NUM_WATCH-1:0] en_q,
    input logic [DATA_W-1:0]    mask_q,
    input logic [DATA_W-1:0]    stat_word,
    input logic                 irq_o
);
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !rd_chg |=> ((flags & $past(flags)) == $past(flags)));  // R2

    AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (rst)
        rd_chg |=> (flags == $past(edge_hit)));  // R3

    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !stat_word[DATA_W-1]);  // R4

    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |=> !irq_o);  // R6

    AST_IRQ_CAUSED: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|(stat_word & mask_q)));  // R6

    AST_RAW_TOP_SET: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd2) |-> reg_rdata[DATA_W-1]);  // R7
endmodule

bind ipc_irq_unit ipc_irq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .rd_chg    (rd_chg),
    .flags     (flags),
    .edge_hit  (edge_hit),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .stat_word (8'(status)),
    .irq_o     (irq_o)
);

// File: tb/tb_ipc_irq_unit.sv
module tb_ipc_irq_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = '0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] gp_in = '0;
    logic [6:0] src_lvl = '0;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ipc_irq_unit dut (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .gp_in     (gp_in),
        .src_lvl   (src_lvl),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        reg_rd   = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rst = 1'b1;
        step(4);
        rst = 1'b0;
        step(1);
        check("R1 irq after reset", {7'd0, irq_o}, 8'h00);
        rd(2'd0, d); check("R1 change word after reset", d, 8'h00);
        rd(2'd1, d); check("R1 status after reset", d, 8'h00);
    endtask

    task automatic t_levels_flags;
        logic [7:0] d;
        gp_in[2] = 1'b1;
        step(2);
        rd(2'd0, d); check("R2 level before flag", d, 8'h04);
        rd(2'd0, d); check("R3 edge kept during read", d, 8'h44);
        rd(2'd0, d); check("R3 flags cleared by read", d, 8'h04);
        gp_in[2] = 1'b0;
        step(4);
        rd(2'd0, d); check("R2 flag on falling edge", d, 8'h40);
        rd(2'd0, d); check("R3 cleared after fall", d, 8'h00);
    endtask

    task automatic t_concurrent;
        logic [7:0] d;
        gp_in[0] = 1'b1;
        step(4);
        gp_in[1] = 1'b1;
        step(2);
        rd(2'd0, d); check("R3 old flag at clearing read", d, 8'h13);
        rd(2'd0, d); check("R3 same-edge change survives", d, 8'h23);
        rd(2'd0, d); check("R3 final clear", d, 8'h03);
    endtask

    task automatic t_enable_gate;
        logic [7:0] d;
        wr(2'd1, 8'h80);
        gp_in[3] = 1'b1;
        step(4);
        rd(2'd1, d); check("R4 gated flag not in status", d, 8'h00);
        check("R4 no irq while gated", {7'd0, irq_o}, 8'h00);
        wr(2'd0, 8'h08);
        rd(2'd1, d); check("R4 enabled flag in status", d, 8'h80);
        check("R6 irq high one cycle later", {7'd0, irq_o}, 8'h01);
        rd(2'd2, d); check("R7 raw read", d, 8'h8B);
        rd(2'd1, d); check("R9 status/raw reads keep flag", d, 8'h80);
        rd(2'd0, d); check("R8 enable write left change word", d, 8'h8B);
        rd(2'd1, d); check("R3 read clears port-change bit", d, 8'h00);
        check("R6 irq low after clear", {7'd0, irq_o}, 8'h00);
        gp_in[0] = 1'b0;
        step(4);
        rd(2'd1, d); check("R4 other flag still gated", d, 8'h00);
        rd(2'd0, d); check("R4 gated flag visible", d, 8'h1A);
    endtask

    task automatic t_sources;
        logic [7:0] d;
        wr(2'd1, 8'h00);
        for (int i = 0; i < 7; i++) begin
            src_lvl = 7'(1 << i);
            rd(2'd1, d); check($sformatf("R5 source bit %0d", i), d, 8'(1 << i));
            check("R6 masked source no irq", {7'd0, irq_o}, 8'h00);
        end
        src_lvl = 7'h08;
        wr(2'd1, 8'h08);
        step(1);
        check("R6 counter bit unmasked", {7'd0, irq_o}, 8'h01);
        src_lvl = 7'h10;
        step(1);
        check("R6 masked-off source drops irq", {7'd0, irq_o}, 8'h00);
        src_lvl = 7'h21;
        wr(2'd1, 8'hFF);
        rd(2'd1, d); check("R8 mask write left status", d, 8'h21);
        step(1);
        check("R6 full mask irq", {7'd0, irq_o}, 8'h01);
        src_lvl = 7'h00;
        step(1);
        check("R6 no sources no irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_raw;
        logic [7:0] d;
        gp_in = 7'b1010101;
        step(2);
        rd(2'd2, d); check("R7 raw pattern", d, 8'hD5);
        gp_in = 7'b0000000;
        step(2);
        rd(2'd2, d); check("R7 raw all low", d, 8'h80);
    endtask

    initial begin
        t_reset();
        t_levels_flags();
        t_concurrent();
        t_enable_gate();
        t_sources();
        t_raw();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule